// File: doc/BRIEF.md
# Programmable Parallel Port Interface

This block is a peripheral on a processor bus. It has three 8-bit parallel ports and one control register. The processor reaches them through a chip select, active-low read and write strobes, a two-bit address and an 8-bit data path. The data path is split into separate input, output and output-enable signals, so that a bidirectional pad can be placed outside the block. All bus writes are taken on the rising clock edge while both the select and the write strobe are low. Reads are combinational while both the select and the read strobe are low.

The control register sets the direction of three things: the first port, the second port, and each 4-bit half of the third port. Every port works in plain input/output mode. A port set as output shows its latched value on its pins and holds that value. A port set as input is not latched: a read returns the value on its pins at that moment. Writing a control word with the top bit clear does not change the configuration. Instead it sets or clears a single bit of the third port's output latch. Writing a configuration word clears every output latch. After reset every port is an input, so the block is usable without any setup.

Top module: `par_port_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, the control word becomes 8'h9B, every output latch clears to zero and every output enable goes low. No write is needed after release before ports can be read as inputs.
- R2: Address 0 selects the first port, 1 the second port, 2 the third port and 3 the control register. A write changes only the selected register.
- R3: `doe` is high exactly while `cs_n` and `rd_n` are both low. `dout` is zero whenever `doe` is low.
- R4: A control write with bit 7 = 1 is a configuration word. The direction bits are: bit 4 for the first port, bit 3 for the upper half of the third port, bit 1 for the second port and bit 0 for the lower half of the third port. A 1 means input. Each pin's output enable is high from the next cycle only if its port or half-port is an output.
- R5: Every configuration write clears all three output latches to zero.
- R6: An output port holds the last value written to it. A read of an output port returns its latch and ignores its pins.
- R7: A read of an input port returns the current pin values, with no latching.
- R8: The two halves of the third port are directed separately. A read of the third port merges the latch nibble of an output half with the pin nibble of an input half.
- R9: A control write with bit 7 = 0 is a single-bit command. Bits 3:1 select the bit of the third port's latch, and bit 0 is the new value. The configuration and all other latch bits stay unchanged.
- R10: A read of address 3 returns the last configuration word as it was written. Nonzero mode fields (bits 6:5 and bit 2) are accepted and behave as plain input/output mode.
- R11: With `cs_n` high, the write strobe has no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select |
| din | input | 8 | Write data from bus |
| dout | output | 8 | Read data to bus |
| doe | output | 1 | Bus drive enable |
| pa_in | input | 8 | First port pin inputs |
| pa_out | output | 8 | First port output latch |
| pa_oe | output | 8 | First port per-pin output enable |
| pb_in | input | 8 | Second port pin inputs |
| pb_out | output | 8 | Second port output latch |
| pb_oe | output | 8 | Second port per-pin output enable |
| pc_in | input | 8 | Third port pin inputs |
| pc_out | output | 8 | Third port output latch |
| pc_oe | output | 8 | Third port per-pin output enable |

## Verification
A corrupted control word appears on the output-enable pins in the cycle after the write that caused it. It is also visible at once in a read of address 3. A latch that is written, cleared or bit-modified wrongly appears on its out pins right after the faulty edge. A fault in the read multiplexer appears as soon as a read is made, in that same cycle, because the read path holds no register. The bench therefore compares pins and read data immediately after each bus access.

// File: rtl/par_port_pkg.sv
// Package: shared widths, register select codes and reset word for the
// parallel port unit. Assumes a byte-wide bus and three byte-wide ports.
package par_port_pkg;
    localparam int DW   = 8;
    localparam int HW   = DW / 2;
    localparam int IDXW = $clog2(DW);
    localparam logic [DW-1:0] CFG_RESET = 8'h9B;

    // Bit positions inside a configuration word.
    localparam int CFG_FLAG  = 7;
    localparam int DIR_A     = 4;
    localparam int DIR_CHI   = 3;
    localparam int DIR_B     = 1;
    localparam int DIR_CLO   = 0;

    typedef enum logic [1:0] {
        SEL_PA  = 2'd0,
        SEL_PB  = 2'd1,
        SEL_PC  = 2'd2,
        SEL_CFG = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic a_in;
        logic b_in;
        logic chi_in;
        logic clo_in;
    } dir_t;
endpackage

// File: rtl/ppu_bus_decode.sv
// Bus decoder: turns select, strobes and address into one-cycle write
// enables per register and a read enable. Assumes strobes are sampled on
// the clock and held by the master for at least one edge.
module ppu_bus_decode
    import par_port_pkg::*;
#(
    parameter int W = DW
) (
    input  logic         cs_n,
    input  logic         rd_n,
    input  logic         wr_n,
    input  logic [1:0]   addr,
    input  logic [W-1:0] din,
    output logic [2:0]   wr_port,
    output logic         wr_cfg,
    output logic         wr_bit,
    output logic         rd_en
);
    logic acc_wr;

    // Decode a write access into a per-register enable.
    always_comb begin
        acc_wr  = !cs_n && !wr_n;
        wr_port = 3'b000;
        wr_cfg  = 1'b0;
        wr_bit  = 1'b0;
        rd_en   = !cs_n && !rd_n;
        if (acc_wr) begin
            case (reg_sel_e'(addr))
                SEL_PA:  wr_port[0] = 1'b1;
                SEL_PB:  wr_port[1] = 1'b1;
                SEL_PC:  wr_port[2] = 1'b1;
                default: begin
                    wr_cfg = din[CFG_FLAG];
                    wr_bit = !din[CFG_FLAG];
                end
            endcase
        end
    end
endmodule

// File: rtl/ppu_cfg_reg.sv
// Configuration register: keeps the last configuration word and derives
// port directions from it. Mode fields are stored but otherwise unused.
module ppu_cfg_reg
    import par_port_pkg::*;
#(
    parameter int W = DW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] word,
    output dir_t         dir
);
    // Hold the configuration word; reset selects all-input.
    always_ff @(posedge clk) begin
        if (!rst_n)    word <= CFG_RESET;
        else if (load) word <= wdata;
    end

    // Extract per-group direction flags (1 = input).
    always_comb begin
        dir.a_in   = word[DIR_A];
        dir.b_in   = word[DIR_B];
        dir.chi_in = word[DIR_CHI];
        dir.clo_in = word[DIR_CLO];
    end
endmodule

// File: rtl/ppu_out_latch.sv
// Output latch for one port: full-width write, clear on reconfiguration,
// and optional single-bit update when BIT_OPS is set.
module ppu_out_latch
    import par_port_pkg::*;
#(
    parameter int W       = DW,
    parameter bit BIT_OPS = 1'b0,
    localparam int IW     = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr,
    input  logic [W-1:0]  wdata,
    input  logic          bit_wr,
    input  logic [IW-1:0] bit_idx,
    input  logic          bit_val,
    output logic [W-1:0]  q
);
    // Update the latch: clear has priority, then full write, then bit op.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)          q <= '0;
        else if (wr)                q <= wdata;
        else if (BIT_OPS && bit_wr) q[bit_idx] <= bit_val;
    end
endmodule

// File: rtl/ppu_read_mux.sv
// Read path: selects latch, pins or configuration word by address and
// direction; forces zero when no read is in progress.
module ppu_read_mux
    import par_port_pkg::*;
#(
    parameter int W  = DW,
    localparam int H = W / 2
) (
    input  logic         rd_en,
    input  logic [1:0]   addr,
    input  dir_t         dir,
    input  logic [W-1:0] cfg_word,
    input  logic [W-1:0] a_lat,
    input  logic [W-1:0] b_lat,
    input  logic [W-1:0] c_lat,
    input  logic [W-1:0] a_pin,
    input  logic [W-1:0] b_pin,
    input  logic [W-1:0] c_pin,
    output logic [W-1:0] rdata
);
    logic [W-1:0] c_view;

    // Build the third port's read value half by half.
    always_comb begin
        c_view[W-1:H] = dir.chi_in ? c_pin[W-1:H] : c_lat[W-1:H];
        c_view[H-1:0] = dir.clo_in ? c_pin[H-1:0] : c_lat[H-1:0];
    end

    // Select the read source by address.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (reg_sel_e'(addr))
                SEL_PA:  rdata = dir.a_in ? a_pin : a_lat;
                SEL_PB:  rdata = dir.b_in ? b_pin : b_lat;
                SEL_PC:  rdata = c_view;
                default: rdata = cfg_word;
            endcase
        end
    end
endmodule

// File: rtl/par_port_unit.sv
// Top level of the parallel port unit. Joins bus decode, configuration
// register, three output latches and the read path; drives per-pin
// output enables from the stored directions. Assumes one clock domain.
module par_port_unit
    import par_port_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          doe,
    input  logic [DW-1:0] pa_in,
    output logic [DW-1:0] pa_out,
    output logic [DW-1:0] pa_oe,
    input  logic [DW-1:0] pb_in,
    output logic [DW-1:0] pb_out,
    output logic [DW-1:0] pb_oe,
    input  logic [DW-1:0] pc_in,
    output logic [DW-1:0] pc_out,
    output logic [DW-1:0] pc_oe
);
    logic [2:0]    wr_port;
    logic          wr_cfg;
    logic          wr_bit;
    logic          rd_en;
    logic [DW-1:0] cfg_word;
    dir_t          dir;
    logic [DW-1:0] lat [3];

    ppu_bus_decode #(.W(DW)) u_dec (
        .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .din(din),
        .wr_port(wr_port), .wr_cfg(wr_cfg), .wr_bit(wr_bit), .rd_en(rd_en)
    );

    ppu_cfg_reg #(.W(DW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .load(wr_cfg), .wdata(din),
        .word(cfg_word), .dir(dir)
    );

    for (genvar p = 0; p < 3; p++) begin : g_lat
        ppu_out_latch #(.W(DW), .BIT_OPS(p == 2)) u_lat (
            .clk(clk), .rst_n(rst_n), .clr(wr_cfg), .wr(wr_port[p]),
            .wdata(din), .bit_wr(wr_bit), .bit_idx(din[IDXW:1]),
            .bit_val(din[0]), .q(lat[p])
        );
    end

    ppu_read_mux #(.W(DW)) u_rd (
        .rd_en(rd_en), .addr(addr), .dir(dir), .cfg_word(cfg_word),
        .a_lat(lat[0]), .b_lat(lat[1]), .c_lat(lat[2]),
        .a_pin(pa_in), .b_pin(pb_in), .c_pin(pc_in), .rdata(dout)
    );

    // Drive pins and per-pin enables from latches and directions.
    always_comb begin
        doe    = rd_en;
        pa_out = lat[0];
        pb_out = lat[1];
        pc_out = lat[2];
        pa_oe  = {DW{!dir.a_in}};
        pb_oe  = {DW{!dir.b_in}};
        pc_oe  = {{HW{!dir.chi_in}}, {HW{!dir.clo_in}}};
    end
endmodule

// File: rtl/par_port_chk.sv
// Checker for the parallel port unit, attached by bind. Observes ports
// only and checks reset state, bus drive, configuration and latch rules.
module par_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       rd_n,
    input logic       wr_n,
    input logic [1:0] addr,
    input logic [7:0] din,
    input logic       doe,
    input logic [7:0] pa_out,
    input logic [7:0] pa_oe,
    input logic [7:0] pb_out,
    input logic [7:0] pb_oe,
    input logic [7:0] pc_out,
    input logic [7:0] pc_oe
);
    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pa_oe == 8'h00 && pb_oe == 8'h00 && pc_oe == 8'h00
                          && pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00));

    p_no_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || rd_n) |-> !doe);

    p_cfg_dirs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !wr_n && addr == 2'd3 && din[7]) |=>
        (pa_oe == {8{!$past(din[4])}} && pb_oe == {8{!$past(din[1])}}
         && pc_oe == {{4{!$past(din[3])}}, {4{!$past(din[0])}}}));

    p_cfg_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !wr_n && addr == 2'd3 && din[7]) |=>
        (pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || wr_n) |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out)));

    p_bit_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !wr_n && addr == 2'd3 && !din[7]) |=>
        ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)
         && $stable(pa_out) && $stable(pb_out)));

    p_deselect_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));
endmodule

bind par_port_unit par_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .din(din), .doe(doe),
    .pa_out(pa_out), .pa_oe(pa_oe), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_out(pc_out), .pc_oe(pc_oe)
);

// File: tb/par_port_unit_test.sv
// Directed bench for the parallel port unit: one task per scenario.
module par_port_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = 2'd0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       doe;
    logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    par_port_unit uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .din(din), .dout(dout), .doe(doe),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; addr = a; din = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = a;
        #2;
        d = dout;
        chk("R3 doe during read", {7'd0, doe}, 8'h01);
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic apply_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [7:0] r;
        apply_reset();
        chk("R1 pa_oe", pa_oe, 8'h00);
        chk("R1 pb_oe", pb_oe, 8'h00);
        chk("R1 pc_oe", pc_oe, 8'h00);
        chk("R1 pa_out", pa_out, 8'h00);
        chk("R1 pc_out", pc_out, 8'h00);
        bus_read(2'd3, r);
        chk("R1 cfg word", r, 8'h9B);
        #1;
        chk("R3 idle doe", {7'd0, doe}, 8'h00);
        chk("R3 idle dout", dout, 8'h00);
    endtask

    task automatic t_inputs_live();
        logic [7:0] r;
        pa_in = 8'h5A; bus_read(2'd0, r); chk("R7 port a pins", r, 8'h5A);
        pa_in = 8'hC3; bus_read(2'd0, r); chk("R7 port a pins changed", r, 8'hC3);
        pb_in = 8'h71; bus_read(2'd1, r); chk("R7 port b pins", r, 8'h71);
        pc_in = 8'h2E; bus_read(2'd2, r); chk("R7 port c pins", r, 8'h2E);
    endtask

    task automatic t_cfg_dirs();
        logic [7:0] r;
        bus_write(2'd3, 8'h80);
        chk("R4 all out pa_oe", pa_oe, 8'hFF);
        chk("R4 all out pb_oe", pb_oe, 8'hFF);
        chk("R4 all out pc_oe", pc_oe, 8'hFF);
        bus_write(2'd3, 8'h82);
        chk("R4 b input pb_oe", pb_oe, 8'h00);
        chk("R4 b input pa_oe", pa_oe, 8'hFF);
        bus_read(2'd3, r);
        chk("R10 cfg readback", r, 8'h82);
        bus_write(2'd3, 8'hE4);
        chk("R10 mode bits pa_oe", pa_oe, 8'hFF);
        chk("R10 mode bits pb_oe", pb_oe, 8'hFF);
        chk("R10 mode bits pc_oe", pc_oe, 8'hFF);
        bus_read(2'd3, r);
        chk("R10 cfg readback mode bits", r, 8'hE4);
    endtask

    task automatic t_latch_hold();
        logic [7:0] r;
        bus_write(2'd3, 8'h80);
        bus_write(2'd0, 8'h3C);
        chk("R2 a written", pa_out, 8'h3C);
        chk("R2 b untouched", pb_out, 8'h00);
        chk("R2 c untouched", pc_out, 8'h00);
        bus_write(2'd1, 8'hA5);
        bus_write(2'd2, 8'h96);
        chk("R2 a kept after b,c", pa_out, 8'h3C);
        pa_in = 8'h11;
        bus_read(2'd0, r);
        chk("R6 read output a", r, 8'h3C);
        repeat (4) @(negedge clk);
        chk("R6 hold a", pa_out, 8'h3C);
        chk("R6 hold b", pb_out, 8'hA5);
        chk("R6 hold c", pc_out, 8'h96);
    endtask

    task automatic t_cfg_clear();
        bus_write(2'd3, 8'h80);
        chk("R5 clear a", pa_out, 8'h00);
        chk("R5 clear b", pb_out, 8'h00);
        chk("R5 clear c", pc_out, 8'h00);
    endtask

    task automatic t_c_halves();
        logic [7:0] r;
        bus_write(2'd3, 8'h81);
        chk("R8 lower in pc_oe", pc_oe, 8'hF0);
        pc_in = 8'h5A;
        bus_write(2'd2, 8'hB7);
        chk("R8 pc_out latch", pc_out, 8'hB7);
        bus_read(2'd2, r);
        chk("R8 merge upper latch", r, 8'hBA);
        bus_write(2'd3, 8'h88);
        chk("R8 upper in pc_oe", pc_oe, 8'h0F);
        bus_write(2'd2, 8'h3C);
        pc_in = 8'hE1;
        bus_read(2'd2, r);
        chk("R8 merge lower latch", r, 8'hEC);
    endtask

    task automatic t_bit_cmd();
        logic [7:0] r;
        bus_write(2'd3, 8'h80);
        bus_write(2'd3, 8'h0F);
        chk("R9 set bit 7", pc_out, 8'h80);
        bus_write(2'd3, 8'h05);
        chk("R9 set bit 2", pc_out, 8'h84);
        bus_write(2'd3, 8'h0E);
        chk("R9 clear bit 7", pc_out, 8'h04);
        bus_read(2'd3, r);
        chk("R9 cfg unchanged", r, 8'h80);
        chk("R9 pa_oe unchanged", pa_oe, 8'hFF);
    endtask

    task automatic t_deselect();
        logic [7:0] r;
        bus_write(2'd0, 8'h42);
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b0; addr = 2'd0; din = 8'hFF;
        @(negedge clk);
        addr = 2'd3; din = 8'h9B;
        @(negedge clk);
        wr_n = 1'b1;
        chk("R11 a unchanged", pa_out, 8'h42);
        chk("R11 oe unchanged", pa_oe, 8'hFF);
        bus_read(2'd3, r);
        chk("R11 cfg unchanged", r, 8'h80);
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b0; #2;
        chk("R3 no drive without select", {7'd0, doe}, 8'h00);
        chk("R3 dout zero without select", dout, 8'h00);
        rd_n = 1'b1;
    endtask

    task automatic t_reset_mid();
        logic [7:0] r;
        apply_reset();
        chk("R1 mid reset pa_out", pa_out, 8'h00);
        chk("R1 mid reset pa_oe", pa_oe, 8'h00);
        chk("R1 mid reset pc_out", pc_out, 8'h00);
        pb_in = 8'h6D;
        bus_read(2'd1, r);
        chk("R1 input ready after reset", r, 8'h6D);
    endtask

    initial begin
        t_reset();
        t_inputs_live();
        t_cfg_dirs();
        t_latch_hold();
        t_cfg_clear();
        t_c_halves();
        t_bit_cmd();
        t_deselect();
        t_reset_mid();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired got running expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule